// File: doc/BRIEF.md
# Per-Queue Token Bucket Shaper

This block limits the egress rate of eight transmit queues. Each queue owns a token bucket, where one token stands for one bit of frame data. A shared prescaler divides the core clock into a base tick. Each queue then counts its own number of base ticks between refills. On each refill the queue's bucket gains a programmed amount of tokens, up to a per-queue ceiling. With a 100 ns tick and a 1000-tick period, one refill unit is worth 10 kbps. The shaped rate is therefore the refill amount times 10 kbps.

A queue that wants to send a frame raises its request line and presents the frame length in bytes. The request is granted in the next cycle only if the bucket holds a positive token count. At that same edge, eight times the length is charged against the bucket. A frame may push the count below zero, and later refills must first pay off that deficit. A command register chooses between this shaping mode and a bypass mode. In bypass mode every queue is eligible and the buckets are held full. A global enable freezes all accounting and timing. Choosing among several eligible queues is left to the logic around the block.

Top module: `egress_token_shaper`

## Requirements
- R1: After reset the block is in bypass mode with every queue eligible and no grant. The reset values are: prescale divisor 1, refill period 1000 ticks, refill amount 0, bucket ceiling 0x7FFFFFFF.
- R2: Register writes use byte addresses. The command register is at 0x3E00, with bit 0 as the limiter switch and bit 3 as the legacy select. The prescale divisor is bits 15:0 at 0x3E08. Queue q's refill register is at 0x3E20+4q, with the period in bits 29:20 and the amount in bits 18:0. Queue q's ceiling is bits 30:0 at 0x3E40+4q. A write to one queue leaves the other queues unchanged.
- R3: Shaping applies only while both command bits are 0. With either bit set, all eligible outputs are 1 and every bucket is loaded with its ceiling.
- R4: Suppose req[q] is high at a rising edge while en is high and queue q is eligible. Then grant[q] is high for the following cycle, and len*8 tokens are taken from bucket q at that same edge.
- R5: A queue is eligible in shaping mode only when its token count is strictly greater than zero. A count of exactly zero is not eligible, and a negative balance carries into later refills.
- R6: The prescaler issues one base tick every P core cycles, where P is the programmed divisor. A divisor of 0 acts as 1.
- R7: A queue with refill period N adds its refill amount on every Nth base tick. A period of 0 stops refills for that queue.
- R8: After any refill the token count never exceeds the queue's ceiling.
- R9: While en is low, no grant is issued and token counts are frozen. The prescaler and all period counters are held at zero, so timing restarts in phase when en rises.
- R10: A request to a queue that is not eligible produces no grant and no charge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable for timing, accounting and grants |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register byte address |
| wr_data | input | 32 | Register write data |
| req | input | 8 | Per-queue start request |
| req_len | input | 112 | Per-queue frame length in bytes, 14 bits per queue, queue q at bits 14q+13:14q |
| grant | output | 8 | Per-queue grant, registered, one cycle per accepted request |
| elig | output | 8 | Per-queue eligibility |

## Verification
A bucket that was charged or refilled wrongly shows up at the eligibility outputs. It becomes visible in the cycle where the count crosses zero, which can be many refill periods after the fault. For this reason the bench drives a queue into deficit. It then checks the exact cycle in which a known number of refills brings the queue back to eligible. A missing ceiling clamp appears only after the clamped bucket is drained: with the clamp, a single frame empties it exactly, and without the clamp the queue stays eligible.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int CMD_ADDR    = 'h3E00;
  localparam int PRESC_ADDR  = 'h3E08;
  localparam int REFILL_BASE = 'h3E20;
  localparam int CEIL_BASE   = 'h3E40;
  localparam int Q_STRIDE    = 4;
  localparam int CMD_LIM_BIT = 0;
  localparam int CMD_OLD_BIT = 3;
  localparam int PER_LSB     = 20;
  localparam int PER_RESET   = 1000;
endpackage

// File: rtl/ets_cfg_regs.sv
module ets_cfg_regs
  import ets_pkg::*;
#(
  parameter int NQ      = 8,
  parameter int AW      = 16,
  parameter int PRESC_W = 16,
  parameter int PER_W   = 10,
  parameter int AMT_W   = 19,
  parameter int CAP_W   = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [31:0]        wr_data,
  output logic               bypass_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [PER_W-1:0]   period_o [NQ],
  output logic [AMT_W-1:0]   amount_o [NQ],
  output logic [CAP_W-1:0]   cap_o    [NQ]
);
  logic lim_on, old_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_on  <= 1'b1;
      old_sel <= 1'b1;
      presc_o <= PRESC_W'(1);
    end else if (wr_en) begin
      if (wr_addr == AW'(CMD_ADDR)) begin
        lim_on  <= wr_data[CMD_LIM_BIT];
        old_sel <= wr_data[CMD_OLD_BIT];
      end
      if (wr_addr == AW'(PRESC_ADDR))
        presc_o <= wr_data[PRESC_W-1:0];
    end
  end

  assign bypass_o = lim_on | old_sel;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic hit_rf, hit_cap;
    assign hit_rf  = wr_en && (wr_addr == AW'(REFILL_BASE + Q_STRIDE*q));
    assign hit_cap = wr_en && (wr_addr == AW'(CEIL_BASE + Q_STRIDE*q));

    always_ff @(posedge clk) begin
      if (rst) begin
        period_o[q] <= PER_W'(PER_RESET);
        amount_o[q] <= '0;
        cap_o[q]    <= '1;
      end else begin
        if (hit_rf) begin
          period_o[q] <= wr_data[PER_LSB +: PER_W];
          amount_o[q] <= wr_data[AMT_W-1:0];
        end
        if (hit_cap)
          cap_o[q] <= wr_data[CAP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ets_tick_gen.sv
module ets_tick_gen #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt;
  logic [PRESC_W:0]   nxt;
  logic               last;

  assign nxt    = {1'b0, cnt} + 1'b1;
  assign last   = (nxt >= {1'b0, presc});
  assign tick_o = !hold && last;

  always_ff @(posedge clk) begin
    if (rst || hold || last) cnt <= '0;
    else                     cnt <= nxt[PRESC_W-1:0];
  end
endmodule

// File: rtl/ets_bucket.sv
module ets_bucket #(
  parameter int PER_W = 10,
  parameter int AMT_W = 19,
  parameter int CAP_W = 31,
  parameter int LEN_W = 14,
  parameter int TOK_W = CAP_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    bypass,
  input  logic                    tick,
  input  logic [PER_W-1:0]        period,
  input  logic [AMT_W-1:0]        amount,
  input  logic [CAP_W-1:0]        cap,
  input  logic                    req,
  input  logic [LEN_W-1:0]        len,
  output logic                    grant_o,
  output logic                    elig_o,
  output logic signed [TOK_W-1:0] tok_o
);
  logic signed [TOK_W-1:0] tok, sum, sat, add_v, sub_v, cap_v;
  logic [PER_W-1:0] pcnt;
  logic             take, refill, wrap;

  assign elig_o = bypass || (!tok[TOK_W-1] && (tok != '0));
  assign take   = run && req && elig_o;
  assign wrap   = (period == '0) || (pcnt >= period - PER_W'(1));
  assign refill = tick && (period != '0) && wrap;

  assign cap_v = $signed(TOK_W'(cap));
  assign add_v = refill ? $signed(TOK_W'(amount)) : '0;
  assign sub_v = take ? $signed(TOK_W'({len, 3'b000})) : '0;
  assign sum   = tok + add_v - sub_v;
  assign sat   = (sum > cap_v) ? cap_v : sum;
  assign tok_o = tok;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok     <= '0;
      pcnt    <= '0;
      grant_o <= 1'b0;
    end else begin
      grant_o <= take;
      if (bypass) begin
        tok  <= cap_v;
        pcnt <= '0;
      end else if (!run) begin
        pcnt <= '0;
      end else begin
        tok <= sat;
        if (tick) pcnt <= wrap ? '0 : pcnt + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/egress_token_shaper.sv
module egress_token_shaper #(
  parameter int NQ      = 8,
  parameter int AW      = 16,
  parameter int PRESC_W = 16,
  parameter int PER_W   = 10,
  parameter int AMT_W   = 19,
  parameter int CAP_W   = 31,
  parameter int LEN_W   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [NQ-1:0]     req,
  input  logic [NQ*LEN_W-1:0] req_len,
  output logic [NQ-1:0]     grant,
  output logic [NQ-1:0]     elig
);
  localparam int TOK_W = CAP_W + 2;

  logic               bypass, tick;
  logic [PRESC_W-1:0] presc;
  logic [PER_W-1:0]   period [NQ];
  logic [AMT_W-1:0]   amount [NQ];
  logic [CAP_W-1:0]   cap    [NQ];
  logic [NQ*TOK_W-1:0] tok_flat;
  logic [NQ*CAP_W-1:0] cap_flat;

  ets_cfg_regs #(
    .NQ(NQ), .AW(AW), .PRESC_W(PRESC_W), .PER_W(PER_W),
    .AMT_W(AMT_W), .CAP_W(CAP_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bypass_o(bypass), .presc_o(presc),
    .period_o(period), .amount_o(amount), .cap_o(cap)
  );

  ets_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk(clk), .rst(rst), .hold(!en || bypass), .presc(presc), .tick_o(tick)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_bkt
    logic signed [TOK_W-1:0] lvl;
    ets_bucket #(
      .PER_W(PER_W), .AMT_W(AMT_W), .CAP_W(CAP_W),
      .LEN_W(LEN_W), .TOK_W(TOK_W)
    ) u_bkt (
      .clk(clk), .rst(rst), .run(en), .bypass(bypass), .tick(tick),
      .period(period[q]), .amount(amount[q]), .cap(cap[q]),
      .req(req[q]), .len(req_len[q*LEN_W +: LEN_W]),
      .grant_o(grant[q]), .elig_o(elig[q]), .tok_o(lvl)
    );
    assign tok_flat[q*TOK_W +: TOK_W] = lvl;
    assign cap_flat[q*CAP_W +: CAP_W] = cap[q];
  end
endmodule

// File: rtl/ets_checker.sv
module ets_checker #(
  parameter int NQ    = 8,
  parameter int CAP_W = 31,
  parameter int TOK_W = CAP_W + 2
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic                bypass,
  input logic [NQ-1:0]       req,
  input logic [NQ-1:0]       grant,
  input logic [NQ-1:0]       elig,
  input logic [NQ*TOK_W-1:0] tok_flat,
  input logic [NQ*CAP_W-1:0] cap_flat
);
  // R3: bypass forces every queue eligible
  assert_bypass_all_elig_R3: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (&elig));

  // R9: frozen accounting while disabled in shaping mode
  assert_frozen_tokens_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(bypass)) |-> (tok_flat == $past(tok_flat)));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    // R4 and R10: a grant needs an enabled request to an eligible queue
    assert_grant_cause_R4: assert property (@(posedge clk) disable iff (rst)
      grant[q] |-> $past(req[q] && en && elig[q]));

    // R8: count stays under the ceiling in force at the previous edge
    assert_under_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
      $signed(tok_flat[q*TOK_W +: TOK_W]) <=
      $signed({2'b00, $past(cap_flat[q*CAP_W +: CAP_W])}));
  end
endmodule

bind egress_token_shaper ets_checker #(.NQ(NQ), .CAP_W(CAP_W), .TOK_W(TOK_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .bypass(bypass), .req(req), .grant(grant),
  .elig(elig), .tok_flat(tok_flat), .cap_flat(cap_flat)
);

// File: tb/tb_egress_token_shaper.sv
module tb_egress_token_shaper;
  localparam int NQ = 8;
  localparam int LEN_W = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NQ-1:0] req = '0;
  logic [NQ*LEN_W-1:0] req_len = '0;
  logic [NQ-1:0] grant, elig;
  logic pend = 1'b0;
  int n_cmp = 0, n_bad = 0;

  typedef struct { int q; bit exp; string tag; } item_t;
  item_t sb[$];

  egress_token_shaper dut (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req(req), .req_len(req_len), .grant(grant), .elig(elig)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'(addr); wr_data = 32'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes expected grant, pulses request for one edge
  task automatic ask(input int q, input int len, input bit exp, input string tag);
    item_t it;
    @(negedge clk);
    req[q] = 1'b1;
    req_len[q*LEN_W +: LEN_W] = LEN_W'(len);
    it.q = q; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    req = '0;
  endtask

  always @(posedge clk) pend <= |req;

  // monitor: compares grant one cycle after each request
  always @(negedge clk) begin
    if (pend) begin
      item_t it;
      if (sb.size() == 0) begin
        chk(1'b0, "R4", "unexpected grant cycle", int'(grant), 0);
      end else begin
        logic [NQ-1:0] want;
        it = sb.pop_front();
        want = it.exp ? (NQ'(1) << it.q) : '0;
        chk(grant == want, it.tag, "grant", int'(grant), int'(want));
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(grant == '0, "R1", "grant after reset", int'(grant), 0);
    chk(elig == '1, "R1", "elig after reset", int'(elig), 'hFF);

    en = 1'b1;
    // R3: bypass grants regardless of length
    ask(0, 1000, 1'b1, "R3");
    ask(0, 1000, 1'b1, "R3");
    // R9: disabled blocks grants
    @(negedge clk) en = 1'b0;
    ask(0, 10, 1'b0, "R9");
    @(negedge clk) en = 1'b1;

    // R2: configure through the register map
    wr('h3E40, 1000);                 // q0 ceiling
    wr('h3E20, 300);                  // q0 period 0, amount 300
    wr('h3E08, 3);                    // divisor 3
    wr('h3E44, 800);                  // q1 ceiling
    wr('h3E24, (1 << 20) | 'h7FFFF);  // q1 period 1, max amount
    wr('h3E00, 0);                    // shaping mode

    // R4, R5: charge q0 into deficit
    ask(0, 100, 1'b1, "R4");
    chk(elig[0] == 1'b1, "R5", "q0 elig at 200", int'(elig[0]), 1);
    ask(0, 100, 1'b1, "R4");
    chk(elig[0] == 1'b0, "R5", "q0 elig at -600", int'(elig[0]), 0);
    ask(0, 1, 1'b0, "R10");
    chk(elig[0] == 1'b0, "R10", "q0 still ineligible", int'(elig[0]), 0);

    // R8: q1 refilled far past its ceiling, then drained exactly
    repeat (12) @(negedge clk);
    wr('h3E24, 5);                    // stop q1 refills
    ask(1, 100, 1'b1, "R8");
    chk(elig[1] == 1'b0, "R8", "q1 empty after 800 bits", int'(elig[1]), 0);
    ask(1, 1, 1'b0, "R5");

    // R3: one command bit set selects bypass
    wr('h3E00, 1);
    chk(elig == '1, "R3", "elig in bypass", int'(elig), 'hFF);
    ask(1, 1, 1'b1, "R3");
    wr('h3E00, 0);

    // R6, R7: refill timing from a known phase
    ask(0, 100, 1'b1, "R4");
    ask(0, 100, 1'b1, "R4");
    chk(elig[0] == 1'b0, "R5", "q0 deficit again", int'(elig[0]), 0);
    @(negedge clk) en = 1'b0;
    wr('h3E20, (2 << 20) | 300);      // q0 period 2, amount 300
    chk(elig[0] == 1'b0, "R9", "q0 frozen while disabled", int'(elig[0]), 0);
    @(negedge clk) en = 1'b1;
    repeat (17) @(negedge clk);
    chk(elig[0] == 1'b0, "R7", "q0 at zero after two refills", int'(elig[0]), 0);
    @(negedge clk);
    chk(elig[0] == 1'b1, "R6", "q0 eligible after third refill", int'(elig[0]), 1);
    ask(0, 1, 1'b1, "R7");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule